// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

The receiver takes a stereo audio stream carried on three wires (bit clock, frame clock and serial data) and turns it into pairs of 24-bit parallel words. All three wires are brought into the system clock domain through a two-stage synchronizer. A rising bit-clock edge is found in that domain, and the frame clock and data are sampled on each such edge. Because the frame clock never changes at a rising bit-clock edge, every half-frame boundary is seen without ambiguity.

A 2-bit format select picks one of four framings. Format 0 is 16-bit data justified to the end of each half-frame. Format 1 is 24-bit data justified to the end of each half-frame. Format 2 is 24-bit data starting at the frame-clock edge. Format 3 is the I2S framing, in which the most significant bit follows the frame-clock edge by one bit clock. The select is captured while reset is held and keeps that value until the next reset. Sixteen-bit samples are placed in the upper bits of the 24-bit word, and the low byte is zero.

A completed left/right pair is offered on a valid/ready output. Once valid is high, it stays high with both words unchanged until ready is seen. A pair that completes while the previous pair is still waiting is discarded, so the older pair is kept. With ready held high, valid is a one-cycle strobe once per frame.

Top module: `audio_serial_rx`

## Requirements
- R1: With format 0, the output word for each channel is the last 16 bits of its half-frame, taken MSB first, in bits 23:8, with bits 7:0 zero. This works at 16, 24 or 32 bit clocks per half-frame.
- R2: With format 1, the output word is the last 24 bits of its half-frame, taken MSB first, at 24 or 32 bit clocks per half-frame. Earlier bits in the half-frame have no effect.
- R3: With format 2, the output word is the first 24 bits of the half-frame, starting with the bit sampled on the first rising bit-clock edge after the frame-clock edge. In formats 0 to 2, frame clock high marks the left channel.
- R4: With format 3, frame clock low marks the left channel. The MSB is the bit at the second rising edge after the frame-clock edge. At 24 or 32 bit clocks per half-frame, 24 bits are taken. At 16 bit clocks per half-frame, 16 bits are taken, placed in bits 23:8 with zeros below.
- R5: A half-frame that was already under way when reset was released produces no word. Only a left word followed by the right word of the same frame produces an output pair.
- R6: The format select is sampled while reset is low. Changes to it after reset is released have no effect.
- R7: While out_valid is high and out_ready is low, out_valid stays high and both words stay unchanged. A pair that completes during that time is discarded.
- R8: While reset is low and just after it is released, out_valid is low.
- R9: With out_ready held high, each complete frame gives exactly one out_valid cycle, in stream order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low reset; the format is sampled while it is low |
| fmt_sel | input | 2 | Framing select: 0 LSB16, 1 LSB24, 2 MSB24, 3 I2S |
| bclk | input | 1 | Serial bit clock, asynchronous |
| lrclk | input | 1 | Frame (channel) clock, asynchronous |
| sdata | input | 1 | Serial data, MSB first, two's complement |
| out_valid | output | 1 | A stereo pair is offered |
| out_ready | input | 1 | The consumer accepts the pair in this cycle |
| out_left | output | 24 | Left channel word |
| out_right | output | 24 | Right channel word |

## Verification
Each format is driven at every half-frame length it supports. This separates the alignment rules: end-justified against start-justified, and one-bit-delayed against undelayed. It also covers the 16-bit I2S case where the final bit falls into the next half-frame. Random fill in the don't-care bit positions shows whether any of them leak into a word. The first frame of each run carries the full-scale codes 0x800000 and 0x7FFFFF, to check the sign and the left alignment. Directed runs cover a format select changed after reset, a partial half-frame before the first boundary, and a consumer that stalls across several frames, so that hold and drop behaviour can be observed.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned NARROW_W = 16;

  typedef enum logic [1:0] {
    FMT_LSB16 = 2'd0,
    FMT_LSB24 = 2'd1,
    FMT_MSB24 = 2'd2,
    FMT_I2S   = 2'd3
  } fmt_e;
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
  import aud_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  fmt_e fmt,
  input  logic bclk_s,
  input  logic lr_s,
  output logic tick,
  output logic lsb_end,
  output logic end_left,
  output logic word_start,
  output logic start_left
);
  logic bclk_d;
  logic lr_last;
  logic primed;
  logic seen_bnd;
  logic dly_pend;
  logic chg;
  logic is_lsb;

  assign is_lsb = (fmt == FMT_LSB16) || (fmt == FMT_LSB24);
  assign tick   = bclk_s & ~bclk_d;
  assign chg    = tick & primed & (lr_s != lr_last);

  // justified end: the half that just closed carried the previous level
  assign lsb_end  = chg & seen_bnd & is_lsb;
  assign end_left = lr_last;

  always_comb begin
    if (fmt == FMT_I2S) begin
      word_start = tick & dly_pend;
      start_left = ~lr_s;
    end else begin
      word_start = chg & ~is_lsb;
      start_left = lr_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d   <= 1'b0;
      lr_last  <= 1'b0;
      primed   <= 1'b0;
      seen_bnd <= 1'b0;
      dly_pend <= 1'b0;
    end else begin
      bclk_d <= bclk_s;
      if (tick) begin
        lr_last  <= lr_s;
        primed   <= 1'b1;
        dly_pend <= chg;
        if (chg) seen_bnd <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
  import aud_rx_pkg::*;
#(
  parameter int unsigned W  = SAMPLE_W,
  parameter int unsigned NW = NARROW_W,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fmt_e         fmt,
  input  logic         tick,
  input  logic         sd_bit,
  input  logic         lsb_end,
  input  logic         end_left,
  input  logic         word_start,
  input  logic         start_left,
  output logic         word_vld,
  output logic [W-1:0] word,
  output logic         word_left
);
  logic [W-1:0]  shreg, n_sh, shifted, narrow, partial, emit_word;
  logic [CW-1:0] cnt, n_cnt, pad;
  logic          active, n_act, cur_left, n_cl;
  logic          emit, emit_left, is_lsb;

  assign is_lsb  = (fmt == FMT_LSB16) || (fmt == FMT_LSB24);
  assign shifted = {shreg[W-2:0], sd_bit};
  assign narrow  = {shreg[NW-1:0], {(W-NW){1'b0}}};
  assign pad     = CW'(W) - cnt;
  assign partial = shreg << pad;

  always_comb begin
    emit      = 1'b0;
    emit_word = '0;
    emit_left = 1'b0;
    n_sh      = shreg;
    n_cnt     = cnt;
    n_act     = active;
    n_cl      = cur_left;
    if (tick) begin
      n_sh = shifted;
      if (is_lsb) begin
        if (lsb_end) begin
          emit      = 1'b1;
          emit_word = (fmt == FMT_LSB16) ? narrow : shreg;
          emit_left = end_left;
        end
      end else if (word_start) begin
        if (active && (cnt != '0)) begin
          emit      = 1'b1;
          emit_word = partial;
          emit_left = cur_left;
        end
        n_cnt = CW'(1);
        n_act = 1'b1;
        n_cl  = start_left;
      end else if (active) begin
        n_cnt = cnt + CW'(1);
        if (n_cnt == CW'(W)) begin
          emit      = 1'b1;
          emit_word = shifted;
          emit_left = cur_left;
          n_act     = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      cnt       <= '0;
      active    <= 1'b0;
      cur_left  <= 1'b0;
      word_vld  <= 1'b0;
      word      <= '0;
      word_left <= 1'b0;
    end else begin
      shreg    <= n_sh;
      cnt      <= n_cnt;
      active   <= n_act;
      cur_left <= n_cl;
      word_vld <= emit;
      if (emit) begin
        word      <= emit_word;
        word_left <= emit_left;
      end
    end
  end
endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_vld,
  input  logic [W-1:0] word,
  input  logic         word_left,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right
);
  logic [W-1:0] lhold;
  logic         have_left;
  logic         load, slot;

  assign load = word_vld & ~word_left & have_left;
  assign slot = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lhold     <= '0;
      have_left <= 1'b0;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      if (word_vld && word_left) begin
        lhold     <= word;
        have_left <= 1'b1;
      end else if (word_vld) begin
        have_left <= 1'b0;
      end
      if (load && slot) begin
        out_left  <= lhold;
        out_right <= word;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int unsigned W         = SAMPLE_W,
  parameter int unsigned NW        = NARROW_W,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   fmt_sel,
  input  logic         bclk,
  input  logic         lrclk,
  input  logic         sdata,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right
);
  logic [1:0]   fmt_q;
  fmt_e         fmt;
  logic [2:0]   pins_s;
  logic         tick, lsb_end, end_left, word_start, start_left;
  logic         word_vld, word_left;
  logic [W-1:0] word;

  always_ff @(posedge clk) begin
    if (!rst_n) fmt_q <= fmt_sel;
  end
  assign fmt = fmt_e'(fmt_q);

  aud_rx_sync #(.W(3), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({bclk, lrclk, sdata}), .q(pins_s)
  );

  aud_rx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .fmt(fmt),
    .bclk_s(pins_s[2]), .lr_s(pins_s[1]),
    .tick(tick), .lsb_end(lsb_end), .end_left(end_left),
    .word_start(word_start), .start_left(start_left)
  );

  aud_rx_deser #(.W(W), .NW(NW)) u_deser (
    .clk(clk), .rst_n(rst_n), .fmt(fmt),
    .tick(tick), .sd_bit(pins_s[0]),
    .lsb_end(lsb_end), .end_left(end_left),
    .word_start(word_start), .start_left(start_left),
    .word_vld(word_vld), .word(word), .word_left(word_left)
  );

  aud_rx_pair #(.W(W)) u_pair (
    .clk(clk), .rst_n(rst_n),
    .word_vld(word_vld), .word(word), .word_left(word_left),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );
endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk #(
  parameter int unsigned W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_left,
  input logic [W-1:0] out_right,
  input logic [1:0]   fmt_q,
  input logic         word_vld
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

  p_fmt_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(fmt_q));

  p_narrow_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fmt_q == 2'd0) |-> (out_left[7:0] == 8'h00 && out_right[7:0] == 8'h00));

  p_word_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);
endmodule

bind audio_serial_rx audio_serial_rx_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_left(out_left), .out_right(out_right), .fmt_q(fmt_q), .word_vld(word_vld)
);

// File: tb/tb_audio_serial_rx.sv
module tb_audio_serial_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [23:0] out_left, out_right;

  audio_serial_rx dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bclk(bclk), .lrclk(lrclk),
    .sdata(sdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, got = 0;
  string tag = "R8";
  logic [23:0] exp_l[$], exp_r[$];
  logic sd_arr[1024], lr_arr[1024];
  int nbits;
  logic pv = 1'b0, pr = 1'b0;
  logic [23:0] pl, prr;

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // output monitor, sampled at the falling clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr)
        check(out_valid && out_left == pl && out_right == prr, "R7 hold",
              {out_left, out_right}, {pl, prr});
      if (out_valid && out_ready) begin
        got++;
        if (exp_l.size() == 0) check(1'b0, tag, {out_left, out_right}, 48'h0);
        else begin
          logic [23:0] el, er;
          el = exp_l.pop_front();
          er = exp_r.pop_front();
          check(out_left == el && out_right == er, tag, {out_left, out_right}, {el, er});
        end
      end
    end
    pv = out_valid; pr = out_ready; pl = out_left; prr = out_right;
  end

  task automatic do_reset(input logic [1:0] f);
    @(negedge clk);
    rst_n = 1'b0; fmt_sel = f; bclk = 1'b0;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R8 in reset", {47'h0, out_valid}, 48'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 after release", {47'h0, out_valid}, 48'h0);
  endtask

  task automatic put_sample(input int s, input int h, input int f, input logic [23:0] v,
                            output logic [23:0] expv);
    int nb, first;
    nb = (f == 0 || (f == 3 && h < 24)) ? 16 : 24;
    first = (f == 0) ? s + h - 16 : (f == 1) ? s + h - 24 : (f == 2) ? s : s + 1;
    for (int k = 0; k < nb; k++) sd_arr[first + k] = v[23 - k];
    expv = (nb == 16) ? {v[23:8], 8'h00} : v;
  endtask

  // builds idle lead-in, nfr frames and one trailing half; queues the first keep pairs
  task automatic build(input int f, input int h, input int nfr, input int keep);
    logic lv, rv;
    logic [23:0] vl, vr, el, er;
    int s;
    lv = (f == 3) ? 1'b0 : 1'b1;
    rv = ~lv;
    nbits = 3 + nfr * 2 * h + h;
    for (int i = 0; i < nbits; i++) sd_arr[i] = 1'($urandom);
    for (int i = 0; i < 3; i++) lr_arr[i] = rv;
    for (int fr = 0; fr < nfr; fr++) begin
      s = 3 + fr * 2 * h;
      for (int i = 0; i < h; i++) begin lr_arr[s + i] = lv; lr_arr[s + h + i] = rv; end
      if (fr == 0) begin vl = 24'h800000; vr = 24'h7FFFFF; end
      else begin vl = 24'($urandom); vr = 24'($urandom); end
      put_sample(s, h, f, vl, el);
      put_sample(s + h, h, f, vr, er);
      if (fr < keep) begin exp_l.push_back(el); exp_r.push_back(er); end
    end
    for (int i = 0; i < h; i++) lr_arr[3 + nfr * 2 * h + i] = lv;
  endtask

  task automatic play();
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      bclk = 1'b0; lrclk = lr_arr[i]; sdata = sd_arr[i];
      repeat (4) @(negedge clk);
      bclk = 1'b1;
      repeat (3) @(negedge clk);
    end
    @(negedge clk);
    bclk = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic run_case(input int f, input int h, input int nfr, input int f_after, input string t);
    tag = t;
    do_reset(2'(f));
    fmt_sel = 2'(f_after);
    got = 0;
    build(f, h, nfr, nfr);
    play();
    check(got == nfr && exp_l.size() == 0, {t, " R9 pair count"}, 48'(got), 48'(nfr));
    exp_l.delete(); exp_r.delete();
  endtask

  initial begin : main
    void'($urandom(32'h5EED_0A17));
    do_reset(2'd0);
    // R1 and R5: the idle lead-in is a partial half before the first boundary
    run_case(0, 16, 4, 0, "R1 lsb16 32fs");
    run_case(0, 32, 3, 0, "R1 lsb16 64fs");
    run_case(1, 24, 3, 1, "R2 lsb24 48fs");
    run_case(1, 32, 4, 1, "R2 lsb24 64fs");
    run_case(2, 24, 3, 2, "R3 msb24 48fs");
    run_case(2, 32, 4, 2, "R3 msb24 64fs");
    run_case(3, 16, 4, 3, "R4 i2s 32fs");
    run_case(3, 24, 3, 3, "R4 i2s 48fs");
    run_case(3, 32, 3, 3, "R4 i2s 64fs");
    run_case(0, 24, 3, 0, "R5 lsb16 48fs");
    // R6: select changed after reset release must be ignored
    run_case(2, 32, 3, 0, "R6 latched fmt");
    // R7: stalled consumer keeps the first pair, later pairs dropped
    tag = "R7 backpressure";
    do_reset(2'd1);
    @(posedge clk); #1 out_ready = 1'b0;
    got = 0;
    build(1, 32, 3, 1);
    play();
    check(out_valid == 1'b1, "R7 still offered", {47'h0, out_valid}, 48'h1);
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (10) @(negedge clk);
    check(got == 1 && exp_l.size() == 0, "R7 only one pair", 48'(got), 48'h1);
    check(out_valid == 1'b0, "R7 valid cleared", {47'h0, out_valid}, 48'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule